// File: doc/BRIEF.md
# Conditional Branch Resolution Unit

This unit takes one 16-bit instruction halfword per cycle, together with the halfword's address and the current N, Z, C and V flags. It resolves the short branch group of the compact instruction set. A conditional short branch has its 4-bit condition evaluated against the flags. An unconditional short branch always redirects. A software-interrupt halfword is expanded into a full 32-bit trap word. The reserved condition value is reported as undefined.

The result appears one clock after the halfword is presented. A taken branch produces a new program-counter value and a pipeline-flush strobe. Every other case produces the sequential address (address + 2) and no flush. A front end uses the flush to discard fetched work and reload from the new value. The trap word goes to the exception path. The flags are computed elsewhere, and the two-halfword branch-with-link sequence is handled elsewhere.

Top module: `cond_branch_unit`

## Requirements
- R1: While rst_n is low, and after its release until the first accepted halfword, res_valid, is_branch, flush, is_trap and is_undef are 0, and pc_value and trap_word are 0.
- R2: A halfword with hw[15:12] = 4'b1101 and hw[11:8] below 4'b1110 is a conditional branch. Its condition field hw[11:8] is encoded 0000 EQ (Z), 0001 NE (!Z), 0010 CS (C), 0011 CC (!C), 0100 MI (N), 0101 PL (!N), 0110 VS (V), 0111 VC (!V), 1000 HI (C & !Z), 1001 LS (!C | Z), 1010 GE (N == V), 1011 LT (N != V), 1100 GT (!Z & N == V) and 1101 LE (Z | N != V).
- R3: A conditional branch whose condition holds gives is_branch = 1 and flush = 1. Its pc_value is addr + 4 + 2 × sign-extended hw[7:0], taken modulo 2^32.
- R4: A conditional branch whose condition fails gives is_branch = 1, flush = 0 and pc_value = addr + 2.
- R5: A halfword with hw[15:11] = 5'b11100 is an unconditional branch. It gives is_branch = 1, flush = 1 and pc_value = addr + 4 + 2 × sign-extended hw[10:0], taken modulo 2^32.
- R6: hw[15:12] = 4'b1101 with hw[11:8] = 4'b1111 is a software interrupt. It gives is_trap = 1, flush = 0 and pc_value = addr + 2. trap_word is 32'hEF000000 with the 8-bit number hw[7:0] in bits [7:0].
- R7: Trap number 8'h18 additionally appears in trap_word[23:16], which gives 32'hEF180018.
- R8: Trap number 8'hFE gives trap_word = {8'hEF, BKPT_CODE}, where BKPT_CODE is a 24-bit parameter.
- R9: hw[15:12] = 4'b1101 with hw[11:8] = 4'b1110 gives is_undef = 1, is_branch = 0, flush = 0 and pc_value = addr + 2.
- R10: Any other halfword gives res_valid = 1 with is_branch, flush, is_trap and is_undef all 0, and pc_value = addr + 2.
- R11: Results appear on the clock after in_valid is sampled high. A cycle with in_valid low gives res_valid = 0, with flush and all class outputs 0.
- R12: At most one of is_branch, is_trap and is_undef is 1 in any cycle, and flush is 1 only together with is_branch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Halfword present this cycle |
| hw | input | 16 | Instruction halfword |
| addr | input | 32 | Address of the halfword |
| flag_n | input | 1 | Negative flag |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| flag_v | input | 1 | Overflow flag |
| res_valid | output | 1 | Result present |
| is_branch | output | 1 | Halfword was a branch, taken or not |
| flush | output | 1 | Taken branch: reload from pc_value |
| pc_value | output | 32 | Next program-counter value |
| is_trap | output | 1 | Software interrupt |
| trap_word | output | 32 | Expanded trap word |
| is_undef | output | 1 | Reserved condition in the branch group |

## Verification
Every one of the 14 condition codes is tried against all 16 flag combinations. This separates a swapped or inverted condition from a correct one, because each code's truth table differs from every other code's in at least one row. The offsets include zero, the largest forward value and the most negative value, for both offset widths, at an address near the top of memory. These cases show whether sign extension, the ×2 scaling and the +4 base are right, and whether the sum wraps. Trap numbers 0x18, 0xFE and their neighbours tell the two substitutions apart from the plain expansion. Idle cycles, the reserved condition and halfwords outside the group confirm that nothing flushes when it should not.

// File: rtl/cond_branch_unit.sv
module cond_branch_unit #(
  parameter int          AW        = 32,
  parameter logic [23:0] BKPT_CODE = 24'h000B57
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [15:0]   hw,
  input  logic [AW-1:0] addr,
  input  logic          flag_n,
  input  logic          flag_z,
  input  logic          flag_c,
  input  logic          flag_v,
  output logic          res_valid,
  output logic          is_branch,
  output logic          flush,
  output logic [AW-1:0] pc_value,
  output logic          is_trap,
  output logic [31:0]   trap_word,
  output logic          is_undef
);
  localparam logic [3:0] GRP_COND = 4'b1101;
  localparam logic [4:0] OP_UNCOND = 5'b11100;
  localparam logic [7:0] NUM_DUP  = 8'h18;
  localparam logic [7:0] NUM_BKPT = 8'hFE;

  logic [3:0] cond;
  logic       cond_true;
  assign cond = hw[11:8];

  always_comb begin
    unique case (cond)
      4'h0: cond_true = flag_z;
      4'h1: cond_true = !flag_z;
      4'h2: cond_true = flag_c;
      4'h3: cond_true = !flag_c;
      4'h4: cond_true = flag_n;
      4'h5: cond_true = !flag_n;
      4'h6: cond_true = flag_v;
      4'h7: cond_true = !flag_v;
      4'h8: cond_true = flag_c && !flag_z;
      4'h9: cond_true = !flag_c || flag_z;
      4'hA: cond_true = flag_n == flag_v;
      4'hB: cond_true = flag_n != flag_v;
      4'hC: cond_true = !flag_z && (flag_n == flag_v);
      4'hD: cond_true = flag_z || (flag_n != flag_v);
      default: cond_true = 1'b0;
    endcase
  end

  logic in_grp, d_bcc, d_b, d_trap, d_undef, d_take;
  assign in_grp  = hw[15:12] == GRP_COND;
  assign d_trap  = in_grp && cond == 4'hF;
  assign d_undef = in_grp && cond == 4'hE;
  assign d_bcc   = in_grp && cond < 4'hE;
  assign d_b     = hw[15:11] == OP_UNCOND;
  assign d_take  = d_b || (d_bcc && cond_true);

  logic [AW-1:0] off_s, off_l, seq_pc, tgt_pc;
  assign off_s  = {{(AW-9){hw[7]}},   hw[7:0],  1'b0};
  assign off_l  = {{(AW-12){hw[10]}}, hw[10:0], 1'b0};
  assign seq_pc = addr + AW'(2);
  assign tgt_pc = addr + AW'(4) + (d_b ? off_l : off_s);

  logic [31:0] d_word;
  always_comb begin
    if (hw[7:0] == NUM_BKPT)     d_word = {8'hEF, BKPT_CODE};
    else if (hw[7:0] == NUM_DUP) d_word = {8'hEF, NUM_DUP, 8'h00, NUM_DUP};
    else                         d_word = {8'hEF, 16'h0000, hw[7:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      is_branch <= 1'b0;
      flush     <= 1'b0;
      is_trap   <= 1'b0;
      is_undef  <= 1'b0;
      pc_value  <= '0;
      trap_word <= '0;
    end else begin
      res_valid <= in_valid;
      is_branch <= in_valid && (d_bcc || d_b);
      flush     <= in_valid && d_take;
      is_trap   <= in_valid && d_trap;
      is_undef  <= in_valid && d_undef;
      if (in_valid) begin
        pc_value  <= d_take ? tgt_pc : seq_pc;
        trap_word <= d_trap ? d_word : 32'h0;
      end
    end
  end
endmodule

// File: rtl/cond_branch_unit_sva.sv
module cond_branch_unit_sva (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [31:0] addr,
  input logic        res_valid,
  input logic        is_branch,
  input logic        flush,
  input logic [31:0] pc_value,
  input logic        is_trap,
  input logic [31:0] trap_word,
  input logic        is_undef
);
  a_r12_one_class: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({is_branch, is_trap, is_undef}));

  a_r12_flush_is_branch: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> is_branch);

  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !res_valid && !flush && !is_branch && !is_trap && !is_undef);

  a_r11_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> res_valid);

  a_r4_sequential_pc: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (flush || pc_value == $past(addr) + 32'd2));

  a_r6_trap_prefix: assert property (@(posedge clk) disable iff (!rst_n)
    is_trap |-> trap_word[31:24] == 8'hEF && !flush);

  a_r9_undef_no_flush: assert property (@(posedge clk) disable iff (!rst_n)
    is_undef |-> !flush);
endmodule

bind cond_branch_unit cond_branch_unit_sva u_sva (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .addr(addr),
  .res_valid(res_valid), .is_branch(is_branch), .flush(flush),
  .pc_value(pc_value), .is_trap(is_trap), .trap_word(trap_word),
  .is_undef(is_undef)
);

// File: tb/cond_branch_unit_bench.sv
`timescale 1ns/1ps
module cond_branch_unit_bench;
  localparam logic [23:0] BKPT = 24'h000B57;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] hw = '0;
  logic [31:0] addr = '0;
  logic        fn = 0, fz = 0, fc = 0, fv = 0;
  logic        res_valid, is_branch, flush, is_trap, is_undef;
  logic [31:0] pc_value, trap_word;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  cond_branch_unit #(.AW(32), .BKPT_CODE(BKPT)) u_cond_branch_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .hw(hw), .addr(addr),
    .flag_n(fn), .flag_z(fz), .flag_c(fc), .flag_v(fv),
    .res_valid(res_valid), .is_branch(is_branch), .flush(flush),
    .pc_value(pc_value), .is_trap(is_trap), .trap_word(trap_word),
    .is_undef(is_undef)
  );

  logic [68:0] exp_q[$];
  string       tag_q[$];

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic bit ref_cond(int c, bit n, bit z, bit cy, bit v);
    case (c)
      0: return z;        1: return !z;
      2: return cy;       3: return !cy;
      4: return n;        5: return !n;
      6: return v;        7: return !v;
      8: return cy && !z; 9: return !cy || z;
      10: return n == v;  11: return n != v;
      12: return !z && n == v;
      13: return z || n != v;
      default: return 0;
    endcase
  endfunction

  task automatic compare_pending();
    logic [68:0] e;
    string t;
    if (exp_q.size() == 0) return;
    e = exp_q.pop_front();
    t = tag_q.pop_front();
    check(t, "res_valid", 32'(res_valid), 32'(e[68]));
    check(t, "is_branch", 32'(is_branch), 32'(e[67]));
    check(t, "flush",     32'(flush),     32'(e[66]));
    check(t, "is_trap",   32'(is_trap),   32'(e[65]));
    check(t, "is_undef",  32'(is_undef),  32'(e[64]));
    if (e[68]) check(t, "pc_value", pc_value, e[63:32]);
    if (e[65]) check(t, "trap_word", trap_word, e[31:0]);
    check("R12", "class_count", 32'($countones({is_branch, is_trap, is_undef}) > 1), 32'd0);
  endtask

  task automatic step(bit v, logic [15:0] h, logic [31:0] a, bit n, bit z, bit cy, bit ov);
    logic [68:0] e;
    string t;
    int o;
    int c;
    bit br, fl, tr, un, tk;
    logic [31:0] pc, tw;
    @(negedge clk);
    compare_pending();
    in_valid = v; hw = h; addr = a; fn = n; fz = z; fc = cy; fv = ov;
    br = 0; fl = 0; tr = 0; un = 0; tw = 0;
    pc = a + 32'd2;
    c = int'(h[11:8]);
    if (!v) t = "R11";
    else if (h[15:12] == 4'hD && c < 14) begin
      br = 1;
      tk = ref_cond(c, n, z, cy, ov);
      if (tk) begin
        o = int'($signed(h[7:0]));
        pc = a + 32'd4 + 32'(o * 2);
        fl = 1; t = "R2/R3";
      end else t = "R2/R4";
    end else if (h[15:12] == 4'hD && c == 15) begin
      tr = 1;
      if (h[7:0] == 8'h18)      begin tw = 32'hEF180018; t = "R7"; end
      else if (h[7:0] == 8'hFE) begin tw = {8'hEF, BKPT};  t = "R8"; end
      else begin tw = 32'hEF000000 + 32'(h[7:0]); t = "R6"; end
    end else if (h[15:12] == 4'hD) begin
      un = 1; t = "R9";
    end else if (h[15:11] == 5'b11100) begin
      o = int'($signed(h[10:0]));
      pc = a + 32'd4 + 32'(o * 2);
      br = 1; fl = 1; t = "R5";
    end else t = "R10";
    if (!v) begin br = 0; fl = 0; tr = 0; un = 0; end
    e = {v, br, fl, tr, un, pc, tw};
    exp_q.push_back(e);
    tag_q.push_back(t);
  endtask

  initial begin
    #(200000 * 8);
    errors++; checks++;
    $display("FAIL R11 watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "res_valid", 32'(res_valid), 0);
    check("R1", "flush", 32'(flush), 0);
    check("R1", "pc_value", pc_value, 0);
    check("R1", "trap_word", trap_word, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "is_branch", 32'(is_branch), 0);
    check("R1", "is_trap", 32'(is_trap), 0);
    check("R1", "is_undef", 32'(is_undef), 0);

    for (int c = 0; c < 14; c++)
      for (int f = 0; f < 16; f++)
        step(1, {4'hD, 4'(c), 8'(f * 17 + c)}, 32'h1000 + 32'(f * 64 + c * 2),
             f[3], f[2], f[1], f[0]);

    step(1, 16'hD07F, 32'h0000_2000, 0, 1, 0, 0);
    step(1, 16'hD080, 32'h0000_2000, 0, 1, 0, 0);
    step(1, 16'hD000, 32'hFFFF_FFFE, 0, 1, 0, 0);
    step(0, 16'hD000, 32'h0000_3000, 0, 1, 0, 0);
    step(1, 16'hE3FF, 32'h0000_4000, 0, 0, 0, 0);
    step(1, 16'hE400, 32'h0000_4000, 1, 1, 1, 1);
    step(1, 16'hE000, 32'h0000_4000, 0, 0, 0, 0);
    step(1, 16'hE3FF, 32'hFFFF_FF00, 0, 0, 0, 0);
    step(1, 16'hE7FF, 32'h0000_0000, 0, 0, 0, 0);

    step(1, 16'hDF18, 32'h5000, 0, 0, 0, 0);
    step(1, 16'hDFFE, 32'h5002, 1, 1, 1, 1);
    step(1, 16'hDF17, 32'h5004, 0, 0, 0, 0);
    step(1, 16'hDFFF, 32'h5006, 0, 0, 0, 0);
    step(1, 16'hDF00, 32'h5008, 0, 1, 0, 0);
    step(1, 16'hDF19, 32'h500A, 0, 0, 0, 0);

    step(1, 16'hDE00, 32'h6000, 0, 1, 0, 0);
    step(1, 16'hDEFF, 32'h6002, 1, 1, 1, 1);

    step(1, 16'h0000, 32'h7000, 0, 1, 0, 0);
    step(1, 16'hE800, 32'h7002, 0, 1, 0, 0);
    step(1, 16'hF800, 32'h7004, 0, 1, 0, 0);
    step(1, 16'hC000, 32'h7006, 0, 1, 0, 0);
    step(1, 16'hF000, 32'h7008, 0, 1, 0, 0);
    step(0, 16'hE000, 32'h7010, 0, 0, 0, 0);
    step(1, 16'hD0F0, 32'h7012, 0, 1, 0, 0);
    step(0, 16'h0000, 32'h0000, 0, 0, 0, 0);
    step(0, 16'h0000, 32'h0000, 0, 0, 0, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule